// File: doc/BRIEF.md
# Phase Accumulator Core with Update-Latched Clearing

This block is the phase-generation half of a direct digital synthesizer. It runs on a fast system clock and advances a 32-bit phase accumulator by an unsigned frequency tuning word on every system clock. It adds a phase offset word to the accumulator and presents the sum as the output phase on every cycle. A sine lookup and a converter further down the chain would consume that phase word.

Configuration is written into a buffered register set that has no effect on the output. The buffered set holds the tuning word, the offset word and an autoclear enable. A separate update request copies the buffered set into the active registers. That request is sampled on a slower sync clock, which exists inside the block as an enable that fires on every fourth system clock edge.

The block reproduces a known transfer order. When autoclear is enabled, the accumulator is cleared at the sync edge that registers the request, but the new words only take effect one full sync cycle later. During that sync cycle the output phase is held at zero, which corresponds to a full-scale cosine. When autoclear is off, the accumulator keeps running with the old tuning word until the new words take effect.

Top module: `ddsCore`

## Requirements
- R1: While reset is asserted, `phaseOut` is 0 and `phaseValid` is 0. From the first system clock edge after reset release, `phaseValid` is 1. Reset leaves the accumulator and all buffered, staged and active words at zero, with autoclear disabled.
- R2: Outside a clear window, the accumulator grows by the active tuning word on every system clock, treated as unsigned and wrapping modulo 2^32. `phaseOut` equals the accumulator plus the active offset word, modulo 2^32.
- R3: A configuration write, meaning `cfgWrite` high at a clock edge, loads only the buffered set. `phaseOut` does not change because of it until an update transfers the buffered set.
- R4: A sync edge is every fourth system clock edge after reset release (the 4th, the 8th, and so on). At each sync edge, `updateReq` is shifted into a two-flop synchroniser. An update is registered at the sync edge where the second flop's value rises from 0 to 1, which is two sync edges after the request is first sampled high.
- R5: If the buffered autoclear bit is 1 when an update registers, the accumulator is zeroed at that edge. `phaseOut` then reads 0 for exactly four system clocks, one sync cycle, with no phase accumulated.
- R6: The tuning and offset words captured at registration become active at the next sync edge, exactly one sync cycle after registration. Afterwards the accumulator advances by the new tuning word, starting from 0 if the update cleared it.
- R7: If the buffered autoclear bit is 0 at registration, the accumulator is not cleared. It keeps advancing by the old tuning word through the pending sync cycle, and `phaseOut` keeps following the old offset until activation.
- R8: A request that stays high registers only one update. Another update needs the request to be seen low at a sync edge first. A rise that arrives while a transfer is pending is ignored.
- R9: The buffered words and autoclear bit are captured at the registering edge. Configuration writes made during the pending sync cycle do not change the transfer in progress. They wait in the buffer for the next update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrite | input | 1 | Load the buffered configuration set |
| cfgFtw | input | 32 | Tuning word to buffer |
| cfgPow | input | 32 | Phase offset word to buffer |
| cfgAutoClr | input | 1 | Autoclear enable to buffer |
| updateReq | input | 1 | Update request, sampled on sync edges |
| phaseOut | output | 32 | Accumulator plus offset, or 0 during a clear window |
| phaseValid | output | 1 | High from the first edge after reset |

## Verification
The assertions check on every cycle that the accumulator advances by exactly the active tuning word whenever no clear is in progress. They also check that the active words only change on an activation strobe, that activation lands exactly one sync cycle after registration, and that a clearing registration leaves both accumulator and output at zero. Only the bench scenarios can show the externally visible timing. That timing covers how many system clocks pass between raising the request and the output change, that the zero glitch spans exactly four cycles, that a held request fires once, and that writes made during a pending transfer stay in the buffer. A behavioural reference model in the bench covers these by comparing against the output on every clock.

// File: rtl/ddsCorePkg.sv
`timescale 1ns/1ps
package ddsCorePkg;
  // strobes from the sync-domain control to the phase datapath
  typedef struct packed {
    logic loadStage;  // update registered: capture buffered set
    logic clearAcc;   // zero the accumulator at registration
    logic holdZero;   // clear window in progress: output forced to zero
    logic activate;   // staged words become active
  } ddsCtrl_t;
endpackage

// File: rtl/ddsSyncCtrl.sv
`timescale 1ns/1ps
module ddsSyncCtrl
  import ddsCorePkg::*;
#(
  parameter int SYNC_RATIO  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     updateReq,
  input  logic     bufAutoClr,
  output ddsCtrl_t ctrl
);
  localparam int CNT_W = (SYNC_RATIO > 2) ? $clog2(SYNC_RATIO) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYNC_RATIO - 1);

  logic [CNT_W-1:0] divCnt;
  logic             syncTick;
  logic [SYNC_STAGES:0] syncShift;  // stages plus one history bit for edge detect
  logic             reqRise;
  logic             pending;
  logic             clrPending;

  // sync-clock enable derived from the system clock
  always_ff @(posedge clk) begin
    if (!rstN) divCnt <= '0;
    else if (divCnt == CNT_LAST) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end
  assign syncTick = (divCnt == CNT_LAST);

  // request synchroniser, advanced only on sync edges
  always_ff @(posedge clk) begin
    if (!rstN) syncShift <= '0;
    else if (syncTick) syncShift <= {syncShift[SYNC_STAGES-1:0], updateReq};
  end
  assign reqRise = syncShift[SYNC_STAGES-1] & ~syncShift[SYNC_STAGES];

  assign ctrl.loadStage = syncTick & reqRise & ~pending;
  assign ctrl.clearAcc  = ctrl.loadStage & bufAutoClr;
  assign ctrl.activate  = syncTick & pending;
  assign ctrl.holdZero  = pending & clrPending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending    <= 1'b0;
      clrPending <= 1'b0;
    end else if (ctrl.loadStage) begin
      pending    <= 1'b1;
      clrPending <= bufAutoClr;
    end else if (ctrl.activate) begin
      pending    <= 1'b0;
      clrPending <= 1'b0;
    end
  end
endmodule

// File: rtl/ddsPhasePath.sv
`timescale 1ns/1ps
module ddsPhasePath
  import ddsCorePkg::*;
#(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ddsCtrl_t           ctrl,
  input  logic               cfgWrite,
  input  logic [PHASE_W-1:0] cfgFtw,
  input  logic [PHASE_W-1:0] cfgPow,
  input  logic               cfgAutoClr,
  output logic               bufAutoClr,
  output logic [PHASE_W-1:0] accVal,
  output logic [PHASE_W-1:0] actFtw,
  output logic [PHASE_W-1:0] actPow,
  output logic [PHASE_W-1:0] phaseOut,
  output logic               phaseValid
);
  logic [PHASE_W-1:0] bufFtw, bufPow;
  logic [PHASE_W-1:0] stgFtw, stgPow;
  logic [PHASE_W-1:0] acc;

  // buffered set: written freely, invisible to the output
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufFtw     <= '0;
      bufPow     <= '0;
      bufAutoClr <= 1'b0;
    end else if (cfgWrite) begin
      bufFtw     <= cfgFtw;
      bufPow     <= cfgPow;
      bufAutoClr <= cfgAutoClr;
    end
  end

  // snapshot taken when the update registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stgFtw <= '0;
      stgPow <= '0;
    end else if (ctrl.loadStage) begin
      stgFtw <= bufFtw;
      stgPow <= bufPow;
    end
  end

  // active words, one sync cycle later
  always_ff @(posedge clk) begin
    if (!rstN) begin
      actFtw <= '0;
      actPow <= '0;
    end else if (ctrl.activate) begin
      actFtw <= stgFtw;
      actPow <= stgPow;
    end
  end

  // accumulator: cleared early, frozen through the clear window
  always_ff @(posedge clk) begin
    if (!rstN) acc <= '0;
    else if (ctrl.clearAcc || ctrl.holdZero) acc <= '0;
    else acc <= acc + actFtw;
  end

  always_ff @(posedge clk) begin
    if (!rstN) phaseValid <= 1'b0;
    else phaseValid <= 1'b1;
  end

  assign accVal   = acc;
  assign phaseOut = ctrl.holdZero ? '0 : (acc + actPow);
endmodule

// File: rtl/ddsCore.sv
`timescale 1ns/1ps
module ddsCore
  import ddsCorePkg::*;
#(
  parameter int PHASE_W     = 32,
  parameter int SYNC_RATIO  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrite,
  input  logic [PHASE_W-1:0] cfgFtw,
  input  logic [PHASE_W-1:0] cfgPow,
  input  logic               cfgAutoClr,
  input  logic               updateReq,
  output logic [PHASE_W-1:0] phaseOut,
  output logic               phaseValid
);
  ddsCtrl_t           ctrl;
  logic               bufAutoClr;
  logic [PHASE_W-1:0] accVal;
  logic [PHASE_W-1:0] actFtw;
  logic [PHASE_W-1:0] actPow;

  ddsSyncCtrl #(
    .SYNC_RATIO (SYNC_RATIO),
    .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .updateReq (updateReq),
    .bufAutoClr(bufAutoClr),
    .ctrl      (ctrl)
  );

  ddsPhasePath #(
    .PHASE_W(PHASE_W)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .cfgWrite  (cfgWrite),
    .cfgFtw    (cfgFtw),
    .cfgPow    (cfgPow),
    .cfgAutoClr(cfgAutoClr),
    .bufAutoClr(bufAutoClr),
    .accVal    (accVal),
    .actFtw    (actFtw),
    .actPow    (actPow),
    .phaseOut  (phaseOut),
    .phaseValid(phaseValid)
  );
endmodule

// File: rtl/ddsCoreChk.sv
`timescale 1ns/1ps
module ddsCoreChk
  import ddsCorePkg::*;
#(
  parameter int PHASE_W    = 32,
  parameter int SYNC_RATIO = 4
) (
  input logic               clk,
  input logic               rstN,
  input ddsCtrl_t           ctrl,
  input logic [PHASE_W-1:0] accVal,
  input logic [PHASE_W-1:0] actFtw,
  input logic [PHASE_W-1:0] actPow,
  input logic [PHASE_W-1:0] phaseOut,
  input logic               phaseValid
);
  // cycles since the last registration, 0 when no transfer is pending
  int sinceLoad;
  always_ff @(posedge clk) begin
    if (!rstN) sinceLoad <= 0;
    else if (ctrl.loadStage) sinceLoad <= 1;
    else if (ctrl.activate) sinceLoad <= 0;
    else if (sinceLoad != 0) sinceLoad <= sinceLoad + 1;
  end

  a_r1_valid_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> phaseValid);

  a_r2_acc_advance: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.clearAcc && !ctrl.holdZero) |=> accVal == PHASE_W'($past(accVal) + $past(actFtw)));

  a_r3_active_stable: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.activate |=> ($stable(actFtw) && $stable(actPow)));

  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clearAcc |=> (accVal == '0 && phaseOut == '0));

  a_r6_one_sync_later: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.activate |-> sinceLoad == SYNC_RATIO);

  a_r8_no_reload: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadStage |-> sinceLoad == 0);

  a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.loadStage, ctrl.activate}));
endmodule

bind ddsCore ddsCoreChk #(
  .PHASE_W   (PHASE_W),
  .SYNC_RATIO(SYNC_RATIO)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .ctrl      (ctrl),
  .accVal    (accVal),
  .actFtw    (actFtw),
  .actPow    (actPow),
  .phaseOut  (phaseOut),
  .phaseValid(phaseValid)
);

// File: tb/ddsCore_test.sv
`timescale 1ns/1ps
module ddsCore_test;
  localparam int W = 32;
  localparam int RATIO = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rstN = 1'b0;
  logic         cfgWrite = 1'b0;
  logic [W-1:0] cfgFtw = '0;
  logic [W-1:0] cfgPow = '0;
  logic         cfgAutoClr = 1'b0;
  logic         updateReq = 1'b0;
  logic [W-1:0] phaseOut;
  logic         phaseValid;

  ddsCore uut (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgFtw(cfgFtw),
    .cfgPow(cfgPow), .cfgAutoClr(cfgAutoClr), .updateReq(updateReq),
    .phaseOut(phaseOut), .phaseValid(phaseValid)
  );

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  bit cmpOn = 1'b0;
  bit done = 1'b0;

  // behavioural reference model
  logic [W-1:0] mAcc, mFtw, mPow, bFtw, bPow, sFtw, sPow;
  bit bClr, sClr, mPend, mValid, q1, q2, q3, mTick, mEvt, mFrz;
  int mCnt;

  always @(posedge clk) begin
    if (!rstN) begin
      mAcc = '0; mFtw = '0; mPow = '0; bFtw = '0; bPow = '0; sFtw = '0; sPow = '0;
      bClr = 0; sClr = 0; mPend = 0; mValid = 0; q1 = 0; q2 = 0; q3 = 0; mCnt = 0;
    end else begin
      mTick = (mCnt == RATIO - 1);
      mEvt  = mTick && q2 && !q3 && !mPend;
      mFrz  = mPend && sClr;
      if ((mEvt && bClr) || mFrz) mAcc = '0;
      else mAcc = mAcc + mFtw;
      if (mTick && mPend) begin
        mFtw = sFtw; mPow = sPow; mPend = 0; sClr = 0;
      end
      if (mEvt) begin
        sFtw = bFtw; sPow = bPow; sClr = bClr; mPend = 1;
      end
      if (cfgWrite) begin
        bFtw = cfgFtw; bPow = cfgPow; bClr = cfgAutoClr;
      end
      if (mTick) begin
        q3 = q2; q2 = q1; q1 = updateReq;
      end
      mCnt = (mCnt + 1) % RATIO;
      mValid = 1;
    end
  end

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn) begin
      check(curReq, phaseOut, (mPend && sClr) ? '0 : (mAcc + mPow));
      check("R1", {31'd0, phaseValid}, {31'd0, mValid});
    end
  end

  task automatic writeCfg(logic [W-1:0] f, logic [W-1:0] p, logic c);
    @(negedge clk);
    cfgWrite = 1'b1; cfgFtw = f; cfgPow = p; cfgAutoClr = c;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic pulseReq(int hold);
    @(negedge clk);
    updateReq = 1'b1;
    repeat (hold) @(negedge clk);
    updateReq = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int zeroCnt;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", phaseOut, '0);
    check("R1", {31'd0, phaseValid}, 32'd0);
    rstN = 1'b1;
    cmpOn = 1'b1;
    idle(10);

    // R4 R6 R7: update without autoclear, wrapping tuning word (R2)
    curReq = "R6";
    writeCfg(32'h4000_0001, 32'h0000_0100, 1'b0);
    pulseReq(8);
    curReq = "R7";
    idle(30);

    // R3: buffered write alone has no effect
    curReq = "R3";
    writeCfg(32'h0ABC_DEF0, 32'h1111_0000, 1'b1);
    idle(40);

    // R2: full-scale tuning word wraps each cycle
    curReq = "R2";
    writeCfg(32'hFFFF_FFFF, 32'h8000_0000, 1'b0);
    pulseReq(8);
    idle(40);

    // set a constant output before the autoclear scenario
    curReq = "R4";
    writeCfg(32'h0, 32'h5, 1'b0);
    pulseReq(8);
    idle(30);

    // R5: autoclear glitch lasts exactly one sync cycle
    curReq = "R5";
    writeCfg(32'h0100_0000, 32'h80, 1'b1);
    zeroCnt = 0;
    @(negedge clk);
    updateReq = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i == 8) updateReq = 1'b0;
      if (phaseOut == '0) zeroCnt++;
    end
    check("R5", zeroCnt, RATIO);
    idle(10);

    // R8: held request fires once; later writes stay buffered
    curReq = "R8";
    writeCfg(32'h0000_3000, 32'h2, 1'b0);
    @(negedge clk);
    updateReq = 1'b1;
    idle(20);
    writeCfg(32'h7777_0000, 32'h3333, 1'b1);
    idle(40);
    updateReq = 1'b0;
    idle(20);

    // R9: writes during the pending cycle do not alter the transfer
    curReq = "R9";
    writeCfg(32'h0002_0000, 32'h40, 1'b1);
    @(negedge clk);
    updateReq = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      cfgWrite = 1'b1; cfgFtw = 32'h1234_0000 + i; cfgPow = 32'h99; cfgAutoClr = 1'b0;
    end
    cfgWrite = 1'b0;
    updateReq = 1'b0;
    idle(40);
    // the last write is applied by a fresh update
    pulseReq(8);
    idle(40);

    cmpOn = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule